// File: doc/BRIEF.md
# RC Servo Pulse Width Digitizer

This block measures how long a radio-control servo command pulse stays high and reports that duration as an 8-bit number. The command is a pulse of roughly 1 to 2 ms, sent about every 20 ms. The raw pulse line is first brought into the local clock domain. A counter then advances on an externally supplied measurement tick for as long as the synchronized pulse is high. When the pulse ends, the count is copied into a holding register. The counter returns to zero, ready for the next pulse.

The tick rate is chosen so that 255 ticks take a little under 2 ms. With that rate the 128-count point falls near 1 ms. The top bit of the result therefore tells whether the pulse was shorter or longer than about 1 ms. The low seven bits then give 128 steps across the 1 to 2 ms span. Pulses longer than full scale read as 255 rather than wrapping to a small number.

Top module: `rc_pulse_digitizer`

## Requirements
- R1: After reset, value_o is 0 and update_o is 0.
- R2: pulse_i passes through two flip-flop stages before use. Edges are found by comparing the newest synchronized sample with the one before it. update_o rises in the third clock cycle after pulse_i falls.
- R3: While the synchronized pulse is high, the counter advances by one on each cycle where tick_i is 1. It does not advance when tick_i is 0.
- R4: Each rising edge of the synchronized pulse restarts the count from zero, whatever the previous pulse left behind.
- R5: On the falling edge of the synchronized pulse, the count is loaded into value_o and the counter is cleared. With tick_i held at 1 and pulse_i high for N clock cycles, the captured value is N-1 (N ≤ 256).
- R6: The count stops at 255. Longer pulses read as 255 and do not wrap.
- R7: Bit 7 of value_o is 0 for captured counts below 128 and 1 for counts of 128 or more. Bits 6:0 then give the count minus 128.
- R8: value_o keeps its value between captures and changes only in the cycle in which update_o is 1.
- R9: update_o is 1 for exactly one clock cycle per capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Measurement tick enable, one clock wide per count step |
| pulse_i | input | 1 | Raw servo pulse, asynchronous to clk_i |
| value_o | output | 8 | Held pulse width of the last completed pulse |
| update_o | output | 1 | One-cycle strobe marking a new value_o |

## Verification
The hardest state to reach from the ports is the saturated counter. It needs a pulse longer than 255 tick periods and must be followed by a clean capture of 255. The stimulus holds tick_i at 1 and keeps pulse_i high for 300 cycles. It then checks that the result is 255, and a short pulse right after it shows the counter was cleared. The 127/128 boundary around bit 7 is reached with pulses of exactly 128 and 129 cycles.

// File: rtl/rc_pulse_pkg.sv
package rc_pulse_pkg;
  parameter int unsigned CNT_W       = 8;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rc_pulse_sync.sv
module rc_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/rc_pulse_counter.sv
module rc_pulse_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] cnt_q;

  // rise restarts, fall clears after capture; count holds at FULL
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (rise_i || fall_i)                  cnt_q <= '0;
    else if (level_i && tick_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rc_pulse_capture.sv
module rc_pulse_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] value_o,
  output logic         update_o
);
  logic [W-1:0] value_q;
  logic         update_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q  <= '0;
      update_q <= 1'b0;
    end else begin
      update_q <= fall_i;
      if (fall_i) value_q <= cnt_i;
    end
  end

  assign value_o  = value_q;
  assign update_o = update_q;
endmodule

// File: rtl/rc_pulse_digitizer.sv
module rc_pulse_digitizer
  import rc_pulse_pkg::*;
#(
  parameter int unsigned W      = CNT_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         pulse_i,
  output logic [W-1:0] value_o,
  output logic         update_o
);
  logic         level_w;
  logic         rise_w;
  logic         fall_w;
  logic [W-1:0] cnt_w;

  rc_pulse_sync #(.STAGES(STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (pulse_i),
    .level_o (level_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  rc_pulse_counter #(.W(W)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_w),
    .rise_i  (rise_w),
    .fall_i  (fall_w),
    .tick_i  (tick_i),
    .cnt_o   (cnt_w)
  );

  rc_pulse_capture #(.W(W)) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall_w),
    .cnt_i    (cnt_w),
    .value_o  (value_o),
    .update_o (update_o)
  );
endmodule

// File: rtl/rc_pulse_digitizer_chk.sv
module rc_pulse_digitizer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         level_w,
  input logic         rise_w,
  input logic         fall_w,
  input logic [W-1:0] cnt_w,
  input logic [W-1:0] value_o,
  input logic         update_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  assert_value_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(value_o));

  assert_strobe_after_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_w |=> update_o && value_o == $past(cnt_w));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == FULL && !rise_w && !fall_w) |=> cnt_w == FULL);

  assert_no_tick_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !rise_w && !fall_w) |=> $stable(cnt_w));

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_w |=> cnt_w == '0);

  assert_idle_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_w && !fall_w) |=> $stable(cnt_w));
endmodule

bind rc_pulse_digitizer rc_pulse_digitizer_chk #(.W(W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .level_w  (level_w),
  .rise_w   (rise_w),
  .fall_w   (fall_w),
  .cnt_w    (cnt_w),
  .value_o  (value_o),
  .update_o (update_o)
);

// File: tb/test_rc_pulse_digitizer.sv
module test_rc_pulse_digitizer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       pulse_i = 1'b0;
  logic [7:0] value_o;
  logic       update_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rc_pulse_digitizer i_rc_pulse_digitizer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .pulse_i  (pulse_i),
    .value_o  (value_o),
    .update_o (update_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // high for n cycles, then sample in the capture cycle (3 cycles after fall)
  task automatic send_pulse(input int n, output int val, output int upd);
    pulse_i = 1'b1;
    repeat (n) @(negedge clk_i);
    pulse_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R2 no strobe before third cycle", int'(update_o), 0);
    @(negedge clk_i);
    val = int'(value_o);
    upd = int'(update_o);
  endtask

  task automatic t_reset;
    check("R1 value_o reset", int'(value_o), 0);
    check("R1 update_o reset", int'(update_o), 0);
  endtask

  task automatic t_basic;
    int v, u;
    send_pulse(50, v, u);
    check("R2 strobe on third cycle", u, 1);
    check("R5 value N-1", v, 49);
    @(negedge clk_i);
    check("R9 strobe one cycle", int'(update_o), 0);
  endtask

  task automatic t_threshold;
    int v, u;
    send_pulse(128, v, u);
    check("R7 127 msb clear", v >> 7, 0);
    check("R5 value 127", v, 127);
    repeat (10) @(negedge clk_i);
    send_pulse(129, v, u);
    check("R7 128 msb set", v >> 7, 1);
    check("R7 128 low bits", v & 8'h7f, 0);
    repeat (10) @(negedge clk_i);
    send_pulse(200, v, u);
    check("R7 199 low bits", v & 8'h7f, 71);
  endtask

  task automatic t_saturate;
    int v, u;
    send_pulse(256, v, u);
    check("R5 value 255 exact", v, 255);
    repeat (5) @(negedge clk_i);
    send_pulse(300, v, u);
    check("R6 saturate at 255", v, 255);
    repeat (5) @(negedge clk_i);
    send_pulse(10, v, u);
    check("R4 restart after saturation", v, 9);
  endtask

  task automatic t_tick_gate;
    int v, u;
    tick_i = 1'b0;
    send_pulse(40, v, u);
    tick_i = 1'b1;
    check("R3 no tick no count", v, 0);
    check("R3 strobe still issued", u, 1);
  endtask

  task automatic t_hold;
    int v, u;
    send_pulse(77, v, u);
    check("R5 value 76", v, 76);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (value_o != 8'd76 || update_o) begin
        check("R8 held between pulses", int'(value_o), 76);
        break;
      end
    end
    check("R8 held after idle", int'(value_o), 76);
  endtask

  task automatic t_back_to_back;
    int v, u;
    send_pulse(3, v, u);
    check("R4 short pulse", v, 2);
    send_pulse(1, v, u);
    check("R4 single-cycle pulse", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_basic();
    repeat (5) @(negedge clk_i);
    t_threshold();
    repeat (5) @(negedge clk_i);
    t_saturate();
    repeat (5) @(negedge clk_i);
    t_tick_gate();
    repeat (5) @(negedge clk_i);
    t_hold();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule